// File: doc/BRIEF.md
# Timer Time Base with Buffered Prescaler and Limit

This block is the counting core of a general-purpose timer. A 16-bit up-counter advances once per prescaler tick. The prescaler divides the system clock by its programmed value plus one. When the counter reaches the active limit on a tick, it wraps to zero and raises an update event. That update event is also the only moment at which the buffered settings move into the copies that the counting logic uses.

Software reaches the block through a small register port. The port has a write strobe, a two-bit address, a data word and a combinational read port. It carries a control word (run, limit buffering, update suppression, forced update), the prescaler value and the counter limit. The outputs are the counter value, a registered update pulse and the delayed counter-enable that actually gates counting.

Top module: `tbase_timer`

## Requirements
- R1: After synchronous reset the counter is 0, the update output and the counter-enable output are low, and every register reads back 0.
- R2: The counter-enable output follows the run bit (control bit 0) one clock later, and counter and prescaler advance only while the counter-enable output is high.
- R3: With prescaler value P the counter advances once every P+1 clocks in which the counter-enable output is high, counting from a cleared prescaler.
- R4: A tick that finds the counter equal to the active limit sets the counter to 0 instead of incrementing it, and clears the prescaler count in the same clock.
- R5: An overflow with update suppression (control bit 2) at 0 produces an update pulse that is high for exactly one clock, namely the first clock in which the counter shows 0.
- R6: With control bit 2 at 1, an overflow still wraps the counter but produces no update pulse.
- R7: Writing the control word with bit 3 set forces an update: both counts clear at that edge, the update output is high on the next clock whatever bit 2 holds, and bit 3 is not stored.
- R8: A prescaler write (address 1) changes the division ratio only from the next update event onward.
- R9: With limit buffering (control bit 1) at 0, a limit write (address 2) becomes the active limit on the clock after the write.
- R10: With control bit 1 at 1, the active limit keeps its value until the next update event and then takes the last written limit.
- R11: Reads return the written values and not the active copies: address 0 gives bits 0 to 2 of the control word with bit 3 as 0, address 1 the prescaler, address 2 the limit, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 prescaler, 2 limit |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 16 | Read data (written values), combinational |
| cnt_o | output | 16 | Current counter value |
| uev_o | output | 1 | Update event pulse |
| cnt_en_o | output | 1 | Delayed counter enable |

## Verification
On every clock the assertions check these rules: the counter only steps by one or returns to zero, it stays frozen while the delayed enable is low, an update pulse always coincides with a zero count, suppressed overflows stay silent, and forced updates clear and pulse. They also check that the active prescaler and a buffered active limit change only on an update event. The actual division rate, the exact clock on which a new ratio or limit begins to act, and the readback values depend on programmed sequences. Only the bench's scenarios can show these, because the expected counts depend on the programmed values and on the moment the writes land.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_PSC  = 2'd1,
        ADDR_LIM  = 2'd2,
        ADDR_NONE = 2'd3
    } addr_e;

    localparam int CTL_RUN   = 0;
    localparam int CTL_BUF   = 1;
    localparam int CTL_QUIET = 2;
    localparam int CTL_FORCE = 3;

    typedef struct packed {
        logic run;
        logic buf_lim;
        logic quiet;
    } ctrl_t;

endpackage

// File: rtl/tbase_regs.sv
module tbase_regs
    import tbase_pkg::*;
#(
    parameter int PSC_W  = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output ctrl_t             ctrl,
    output logic [PSC_W-1:0]  psc_pre,
    output logic [CNT_W-1:0]  lim_pre,
    output logic              sw_req
);

    typedef struct packed {
        ctrl_t            ctl;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] lim;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (addr_e'(wr_addr))
                ADDR_CTRL: begin
                    r_d.ctl.run     = wr_data[CTL_RUN];
                    r_d.ctl.buf_lim = wr_data[CTL_BUF];
                    r_d.ctl.quiet   = wr_data[CTL_QUIET];
                end
                ADDR_PSC: r_d.psc = wr_data[PSC_W-1:0];
                ADDR_LIM: r_d.lim = wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign sw_req  = wr_en && (addr_e'(wr_addr) == ADDR_CTRL) && wr_data[CTL_FORCE];
    assign ctrl    = r_q.ctl;
    assign psc_pre = r_q.psc;
    assign lim_pre = r_q.lim;

    always_comb begin
        rd_data = '0;
        unique case (addr_e'(rd_addr))
            ADDR_CTRL: begin
                rd_data[CTL_RUN]   = r_q.ctl.run;
                rd_data[CTL_BUF]   = r_q.ctl.buf_lim;
                rd_data[CTL_QUIET] = r_q.ctl.quiet;
            end
            ADDR_PSC: rd_data = DATA_W'(r_q.psc);
            ADDR_LIM: rd_data = DATA_W'(r_q.lim);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             uev,
    input  logic             sw_clr,
    input  logic [PSC_W-1:0] psc_pre,
    output logic             tick,
    output logic [PSC_W-1:0] psc_active
);

    typedef struct packed {
        logic [PSC_W-1:0] cnt;
        logic [PSC_W-1:0] ratio;
    } psc_t;

    psc_t p_d, p_q;

    assign tick       = en && (p_q.cnt == p_q.ratio);
    assign psc_active = p_q.ratio;

    always_comb begin
        p_d = p_q;
        if (sw_clr) begin
            p_d.cnt = '0;
        end else if (en) begin
            p_d.cnt = tick ? '0 : p_q.cnt + 1'b1;
        end
        if (uev) begin
            p_d.ratio = psc_pre;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             sw_clr,
    input  logic             uev,
    input  logic             buf_lim,
    input  logic [CNT_W-1:0] lim_pre,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf,
    output logic [CNT_W-1:0] lim_active
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } ctr_t;

    ctr_t c_d, c_q;

    assign lim_active = buf_lim ? c_q.lim : lim_pre;
    assign ovf        = tick && (c_q.cnt == lim_active);
    assign cnt        = c_q.cnt;

    always_comb begin
        c_d = c_q;
        if (sw_clr) begin
            c_d.cnt = '0;
        end else if (tick) begin
            c_d.cnt = ovf ? '0 : c_q.cnt + 1'b1;
        end
        if (!buf_lim || uev) begin
            c_d.lim = lim_pre;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
    import tbase_pkg::*;
#(
    parameter  int CNT_W  = 16,
    parameter  int PSC_W  = 16,
    localparam int DATA_W = (CNT_W > PSC_W) ? CNT_W : PSC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              uev_o,
    output logic              cnt_en_o
);

    typedef struct packed {
        logic en;
        logic uev;
    } top_t;

    top_t t_d, t_q;

    ctrl_t            ctrl;
    logic [PSC_W-1:0] psc_pre;
    logic [CNT_W-1:0] lim_pre;
    logic             sw_req;
    logic             tick;
    logic             ovf;
    logic             uev_now;
    logic [PSC_W-1:0] psc_active;
    logic [CNT_W-1:0] lim_active;
    logic             ctl_run;
    logic             ctl_buf;
    logic             ctl_quiet;

    assign ctl_run   = ctrl.run;
    assign ctl_buf   = ctrl.buf_lim;
    assign ctl_quiet = ctrl.quiet;

    tbase_regs #(
        .PSC_W (PSC_W),
        .CNT_W (CNT_W),
        .DATA_W(DATA_W)
    ) i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .ctrl   (ctrl),
        .psc_pre(psc_pre),
        .lim_pre(lim_pre),
        .sw_req (sw_req)
    );

    tbase_prescaler #(
        .PSC_W(PSC_W)
    ) i_psc (
        .clk       (clk),
        .rst       (rst),
        .en        (t_q.en),
        .uev       (uev_now),
        .sw_clr    (sw_req),
        .psc_pre   (psc_pre),
        .tick      (tick),
        .psc_active(psc_active)
    );

    tbase_counter #(
        .CNT_W(CNT_W)
    ) i_ctr (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .sw_clr    (sw_req),
        .uev       (uev_now),
        .buf_lim   (ctl_buf),
        .lim_pre   (lim_pre),
        .cnt       (cnt_o),
        .ovf       (ovf),
        .lim_active(lim_active)
    );

    assign uev_now = sw_req || (ovf && !ctl_quiet);

    always_comb begin
        t_d     = t_q;
        t_d.en  = ctl_run;
        t_d.uev = uev_now;
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign uev_o    = t_q.uev;
    assign cnt_en_o = t_q.en;

endmodule

// File: rtl/tbase_timer_chk.sv
module tbase_timer_chk #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt_o,
    input logic             uev_o,
    input logic             cnt_en_o,
    input logic             sw_req,
    input logic             ovf,
    input logic             uev_now,
    input logic             ctl_run,
    input logic             ctl_buf,
    input logic             ctl_quiet,
    input logic [PSC_W-1:0] psc_active,
    input logic [CNT_W-1:0] lim_active
);

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en_o && !sw_req) |=> $stable(cnt_o)); // R2

    AST_EN_LAG: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_run) |=> cnt_en_o); // R2

    AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt_o != $past(cnt_o)) |-> (cnt_o == '0 || cnt_o == CNT_W'($past(cnt_o) + 1'b1))); // R4

    AST_UEV_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        uev_o |-> (cnt_o == '0)); // R5

    AST_QUIET_OVF: assert property (@(posedge clk) disable iff (rst)
        (ovf && ctl_quiet && !sw_req) |=> !uev_o); // R6

    AST_FORCE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        sw_req |=> (uev_o && cnt_o == '0)); // R7

    AST_PSC_BUFFERED: assert property (@(posedge clk) disable iff (rst)
        !uev_now |=> $stable(psc_active)); // R8

    AST_LIM_BUFFERED: assert property (@(posedge clk) disable iff (rst)
        (ctl_buf && !uev_now) |=> (!ctl_buf || $stable(lim_active))); // R10

endmodule

bind tbase_timer tbase_timer_chk #(
    .CNT_W(CNT_W),
    .PSC_W(PSC_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_o     (cnt_o),
    .uev_o     (uev_o),
    .cnt_en_o  (cnt_en_o),
    .sw_req    (sw_req),
    .ovf       (ovf),
    .uev_now   (uev_now),
    .ctl_run   (ctl_run),
    .ctl_buf   (ctl_buf),
    .ctl_quiet (ctl_quiet),
    .psc_active(psc_active),
    .lim_active(lim_active)
);

// File: tb/test_tbase_timer.sv
`timescale 1ns/1ps
module test_tbase_timer;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_PSC  = 2'd1;
    localparam logic [1:0] A_LIM  = 2'd2;
    localparam logic [1:0] A_NONE = 2'd3;

    typedef struct packed {
        logic [15:0] psc;
        logic [15:0] lim;
        logic [15:0] n;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{psc: 16'd0, lim: 16'd9,   n: 16'd1},
        '{psc: 16'd0, lim: 16'd9,   n: 16'd2},
        '{psc: 16'd0, lim: 16'd9,   n: 16'd5},
        '{psc: 16'd1, lim: 16'd9,   n: 16'd9},
        '{psc: 16'd2, lim: 16'd3,   n: 16'd20},
        '{psc: 16'd0, lim: 16'd2,   n: 16'd8},
        '{psc: 16'd3, lim: 16'd100, n: 16'd41},
        '{psc: 16'd0, lim: 16'd0,   n: 16'd6},
        '{psc: 16'd4, lim: 16'd1,   n: 16'd26}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [15:0] cnt_o;
    logic        uev_o;
    logic        cnt_en_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    tbase_timer i_tbase_timer (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cnt_o   (cnt_o),
        .uev_o   (uev_o),
        .cnt_en_o(cnt_en_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #0.5;
        v = int'(rd_data);
    endtask

    task automatic prep(input logic [15:0] psc, input logic [15:0] lim, input logic [15:0] bits);
        wr(A_CTRL, 16'd0);
        wr(A_PSC, psc);
        wr(A_LIM, lim);
        wr(A_CTRL, bits | 16'h0008);
    endtask

    function automatic int model_cnt(input int psc, input int lim, input int n);
        int k;
        k = (n > 0) ? n - 1 : 0;
        return (k / (psc + 1)) % (lim + 1);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v;
        int ups;
        int pairs;
        int prev;
        int held;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 cnt", int'(cnt_o), 0);
        check("R1 uev", int'(uev_o), 0);
        check("R1 en", int'(cnt_en_o), 0);
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_PSC, v);  check("R1 psc", v, 0);
        rd(A_LIM, v);  check("R1 lim", v, 0);

        // R3 / R4: table of ratios and limits
        for (int i = 0; i < NVEC; i++) begin
            prep(VECS[i].psc, VECS[i].lim, 16'd0);
            wr(A_CTRL, 16'd1);
            repeat (int'(VECS[i].n)) @(negedge clk);
            check($sformatf("R3 R4 vec%0d", i), int'(cnt_o),
                  model_cnt(int'(VECS[i].psc), int'(VECS[i].lim), int'(VECS[i].n)));
        end

        // R2: enable lag and stopping
        prep(16'd0, 16'd50, 16'd0);
        wr(A_CTRL, 16'd1);
        check("R2 en lag", int'(cnt_en_o), 0);
        @(negedge clk);
        check("R2 en on", int'(cnt_en_o), 1);
        check("R2 cnt still", int'(cnt_o), 0);
        repeat (3) @(negedge clk);
        wr(A_CTRL, 16'd0);
        @(negedge clk);
        check("R2 en off", int'(cnt_en_o), 0);
        held = int'(cnt_o);
        repeat (5) @(negedge clk);
        check("R2 frozen", int'(cnt_o), held);

        // R8: ratio change 1 -> 2 waits for the wrap
        prep(16'd0, 16'd5, 16'd0);
        wr(A_CTRL, 16'd1);
        repeat (4) @(negedge clk);
        check("R8 pre", int'(cnt_o), 3);
        wr(A_PSC, 16'd1);
        check("R8 old ratio", int'(cnt_o), 4);
        rd(A_PSC, v); check("R11 psc read", v, 1);
        @(negedge clk);
        check("R8 old ratio 2", int'(cnt_o), 5);
        @(negedge clk);
        check("R4 wrap", int'(cnt_o), 0);
        check("R5 pulse", int'(uev_o), 1);
        @(negedge clk);
        check("R8 hold", int'(cnt_o), 0);
        check("R5 one cycle", int'(uev_o), 0);
        @(negedge clk);
        check("R8 new ratio", int'(cnt_o), 1);
        repeat (2) @(negedge clk);
        check("R8 new ratio 2", int'(cnt_o), 2);

        // R10: buffered limit
        prep(16'd0, 16'd5, 16'd2);
        wr(A_CTRL, 16'd3);
        repeat (4) @(negedge clk);
        wr(A_LIM, 16'd2);
        check("R10 keeps old", int'(cnt_o), 4);
        @(negedge clk);
        check("R10 reaches old", int'(cnt_o), 5);
        @(negedge clk);
        check("R10 wrap old", int'(cnt_o), 0);
        repeat (2) @(negedge clk);
        check("R10 new lim", int'(cnt_o), 2);
        @(negedge clk);
        check("R10 wrap new", int'(cnt_o), 0);
        check("R10 uev", int'(uev_o), 1);

        // R9: unbuffered limit acts at once
        prep(16'd0, 16'd9, 16'd0);
        wr(A_CTRL, 16'd1);
        repeat (4) @(negedge clk);
        wr(A_LIM, 16'd4);
        check("R9 cnt", int'(cnt_o), 4);
        @(negedge clk);
        check("R9 wrap", int'(cnt_o), 0);
        check("R9 uev", int'(uev_o), 1);

        // R6: suppressed update
        prep(16'd0, 16'd3, 16'd4);
        wr(A_CTRL, 16'd5);
        ups = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (uev_o) ups++;
        end
        check("R6 no uev", ups, 0);
        check("R6 still wraps", int'(cnt_o), 1);

        // R5: pulse count and width
        prep(16'd0, 16'd3, 16'd0);
        wr(A_CTRL, 16'd1);
        ups = 0; pairs = 0; prev = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (uev_o) ups++;
            if (uev_o && prev == 1) pairs++;
            prev = int'(uev_o);
        end
        check("R5 count", ups, 2);
        check("R5 width", pairs, 0);

        // R7: forced update, quiet set, new prescaler loaded
        prep(16'd0, 16'd9, 16'd0);
        wr(A_CTRL, 16'd1);
        repeat (6) @(negedge clk);
        wr(A_PSC, 16'd2);
        check("R7 before", int'(cnt_o), 6);
        wr(A_CTRL, 16'd13);
        check("R7 cleared", int'(cnt_o), 0);
        check("R7 uev", int'(uev_o), 1);
        rd(A_CTRL, v); check("R7 R11 bit3 not kept", v, 5);
        repeat (2) @(negedge clk);
        check("R7 R8 new ratio", int'(cnt_o), 0);
        check("R7 pulse ends", int'(uev_o), 0);
        @(negedge clk);
        check("R7 R8 tick", int'(cnt_o), 1);

        // R11: readback of written values
        wr(A_LIM, 16'hABCD);
        rd(A_LIM, v);  check("R11 lim", v, 16'hABCD);
        wr(A_CTRL, 16'h000E);
        rd(A_CTRL, v); check("R11 ctrl", v, 6);
        rd(A_NONE, v); check("R11 addr3", v, 0);

        // R1: reset while running
        wr(A_CTRL, 16'd1);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 cnt after", int'(cnt_o), 0);
        check("R1 en after", int'(cnt_en_o), 0);
        check("R1 uev after", int'(uev_o), 0);
        rd(A_PSC, v);  check("R1 psc after", v, 0);
        rd(A_LIM, v);  check("R1 lim after", v, 0);
        rd(A_CTRL, v); check("R1 ctrl after", v, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule